// File: doc/BRIEF.md
# Rising-Edge Set/Clear Bit

This block stores one bit with two control inputs, one to set it and one to clear it. It drives the stored bit on one output and its complement on another. Both controls are sampled on a free-running system clock. Only a low-to-high transition of a control has any effect. A control that stays high does nothing after its first cycle, and a control that falls does nothing at all. This lets a level that lingers on one input coexist with later pulses on the other input.

A synchronous, active-high reset puts the stored bit at 1 and the complement at 0. It also clears the per-input history registers. As a result, a control that is already high when reset is released is taken as a fresh transition.

If both controls rise in the same cycle, the outcome is not part of the contract. The implementation lets clear win so that runs repeat exactly.

Top module: `srff_edge`

## Requirements
- R1: When `set_in` is sampled high on a clock edge and was sampled low on the edge before, and `clr_in` does not also rise there, `q` is 1 after that same edge. This gives one cycle of latency from an input change made between edges.
- R2: When `clr_in` is sampled high on a clock edge and was sampled low on the edge before, and `set_in` does not also rise there, `q` is 0 after that edge.
- R3: Outside reset, `q_n` is always the inverse of `q`.
- R4: On an edge where neither control rises, `q` keeps its value. This covers a control held high across edges and a control going from high to low.
- R5: While `rst` is sampled high, `q` becomes 1 and `q_n` becomes 0, whatever the controls do.
- R6: The history of each control reads as low right after reset. A control held high through reset release therefore acts as a rising transition on the first edge with `rst` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| set_in | input | 1 | Set control; its rising transition drives `q` to 1 |
| clr_in | input | 1 | Clear control; its rising transition drives `q` to 0 |
| q | output | 1 | Stored bit |
| q_n | output | 1 | Complement of the stored bit |

## Verification
The bench applies every sequence of four control pairs after a reset, and the first pair is already present during reset. This separates a true transition from a level that is merely high, and a fall from a hold. It also shows whether a level that persists through reset release counts as a transition. It then repeats the full sweep with a randomly chosen starting pair held for several cycles, so that long highs on one input meet pulses on the other. Cycles in which both controls rise are left unchecked for `q`, but the complement relation is still checked there.

// File: rtl/srff_pkg.sv
package srff_pkg;

    // number of control inputs watched for transitions
    localparam int unsigned NUM_CTL = 2;
    localparam int unsigned IDX_SET = 0;
    localparam int unsigned IDX_CLR = 1;

    // value the stored bit takes in reset
    localparam logic START_Q = 1'b1;

    typedef struct packed {
        logic clr;
        logic set;
    } ctl_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2
    } act_e;

    // clear wins when both rise together, keeping runs deterministic
    function automatic act_e pick_action(input ctl_t rise);
        if (rise.clr)      return ACT_CLR;
        else if (rise.set) return ACT_SET;
        else               return ACT_HOLD;
    endfunction

endpackage

// File: rtl/srff_edge_det.sv
module srff_edge_det #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] prev;

    for (genvar i = 0; i < WIDTH; i++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) prev[i] <= 1'b0;
            else     prev[i] <= din[i];
        end

        assign rise[i] = din[i] & ~prev[i];

        // R6: history is low on the first cycle out of reset
        assert_hist_clear_R6: assert property (@(posedge clk)
            $past(rst) |-> (rise[i] == din[i]));
    end

endmodule

// File: rtl/srff_core.sv
module srff_core
    import srff_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t rise,
    output logic q,
    output logic q_n
);

    act_e act;

    assign act = pick_action(rise);

    // two separate flops, so the complement is a register output too
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= START_Q;
            q_n <= ~START_Q;
        end else begin
            unique case (act)
                ACT_SET: begin
                    q   <= 1'b1;
                    q_n <= 1'b0;
                end
                ACT_CLR: begin
                    q   <= 1'b0;
                    q_n <= 1'b1;
                end
                default: begin
                    q   <= q;
                    q_n <= q_n;
                end
            endcase
        end
    end

    assert_set_edge_R1: assert property (@(posedge clk) disable iff (rst)
        (rise.set && !rise.clr) |=> q);

    assert_clr_edge_R2: assert property (@(posedge clk) disable iff (rst)
        (rise.clr && !rise.set) |=> !q);

    assert_compl_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (q != q_n));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!rise.set && !rise.clr) |=> $stable(q));

endmodule

// File: rtl/srff_edge.sv
module srff_edge
    import srff_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_in,
    input  logic clr_in,
    output logic q,
    output logic q_n
);

    logic [NUM_CTL-1:0] ctl_vec;
    logic [NUM_CTL-1:0] rise_vec;
    ctl_t               rise;

    assign ctl_vec[IDX_SET] = set_in;
    assign ctl_vec[IDX_CLR] = clr_in;

    srff_edge_det #(
        .WIDTH(NUM_CTL)
    ) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (ctl_vec),
        .rise (rise_vec)
    );

    assign rise.set = rise_vec[IDX_SET];
    assign rise.clr = rise_vec[IDX_CLR];

    srff_core u_core (
        .clk  (clk),
        .rst  (rst),
        .rise (rise),
        .q    (q),
        .q_n  (q_n)
    );

    assert_start_value_R5: assert property (@(posedge clk)
        $past(rst) |-> (q == START_Q && q_n == ~START_Q));

endmodule

// File: tb/srff_edge_test.sv
module srff_edge_test;

    localparam int CLK_PERIOD = 10;
    localparam int SEQ_LEN    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic set_in = 1'b0;
    logic clr_in = 1'b0;
    logic q, q_n;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic exp_q, ps, pr;
    bit   exp_known;

    always #(CLK_PERIOD/2) clk = ~clk;

    srff_edge uut (
        .clk    (clk),
        .rst    (rst),
        .set_in (set_in),
        .clr_in (clr_in),
        .q      (q),
        .q_n    (q_n)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // called at a negedge: drive pair, model next edge, check after it
    task automatic step(input logic s, input logic r, input bit after_rst);
        logic rs, rr;
        string tag;
        set_in = s;
        clr_in = r;
        rs = s & ~ps;
        rr = r & ~pr;
        ps = s;
        pr = r;
        exp_known = !(rs && rr);
        if (rs && !rr) begin
            exp_q = 1'b1;
            tag = after_rst ? "R6" : "R1";
        end else if (rr && !rs) begin
            exp_q = 1'b0;
            tag = after_rst ? "R6" : "R2";
        end else begin
            tag = "R4";
        end
        @(negedge clk);
        if (exp_known) check(q, exp_q, tag);
        else exp_q = q;
        check(q_n, ~q, "R3");
    endtask

    task automatic run_seq(input logic [2*SEQ_LEN-1:0] pat, input int hold);
        @(negedge clk);
        rst    = 1'b1;
        set_in = pat[0];
        clr_in = pat[1];
        repeat (2) @(negedge clk);
        check(q, 1'b1, "R5");
        check(q_n, 1'b0, "R5");
        rst = 1'b0;
        ps = 1'b0;
        pr = 1'b0;
        exp_q = 1'b1;
        for (int k = 0; k < SEQ_LEN; k++) begin
            for (int h = 0; h < ((k == 0) ? hold : 1); h++)
                step(pat[2*k], pat[2*k+1], (k == 0 && h == 0));
        end
        step(pat[2*SEQ_LEN-2], pat[2*SEQ_LEN-1], 1'b0);
        step(1'b0, 1'b0, 1'b0);
        check(q_n, ~exp_q, "R3");
    endtask

    initial begin
        for (int p = 0; p < (1 << (2*SEQ_LEN)); p++)
            run_seq(p[2*SEQ_LEN-1:0], 1);
        for (int p = 0; p < (1 << (2*SEQ_LEN)); p++)
            run_seq(p[2*SEQ_LEN-1:0], 1 + ($urandom % 4));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule